// File: doc/BRIEF.md
# Packed Multiply-Accumulate and SAD Unit

This unit performs 64-bit packed-integer arithmetic for a SIMD datapath. Each operation takes two 64-bit operands, `a` and `b`, and a 64-bit accumulator `acc`. A 5-bit opcode selects the operation. The operations fall into four groups:

- halfword multiplies that work per lane or pairwise;
- a multiply-accumulate that folds four products into a 64-bit scalar;
- sums of absolute differences over byte or halfword lanes;
- add-across and sign-bit gathers over a single operand.

Each opcode selects whether lanes are read as signed or unsigned values.

The unit computes its result in one combinational stage and registers it, so the latency is fixed at one clock. The surrounding pipeline may issue one operation on every cycle. It qualifies the result with `out_valid`, which follows `in_valid` by one cycle. Flags, saturation and register-file access belong to the surrounding datapath.

In the requirements below, halfword lane i is bits 16i+15:16i, byte lane i is bits 8i+7:8i and word lane i is bits 32i+31:32i.

Top module: `pmac_unit`

## Requirements
- R1: Op 0 (signed) and op 1 (unsigned) perform the pairwise multiply-add. Result[31:0] is the sum of the products of halfword lanes 0 and 1. Result[63:32] is the sum of the products of lanes 2 and 3. Each 32-bit sum wraps modulo 2^32. The signed op sign-extends the lanes and the unsigned op zero-extends them.
- R2: Ops 2 to 5 perform per-lane 16x16 multiplies and place one product half in each lane's own position. The four ops are:
  - op 2: signed, low half (product bits 15:0);
  - op 3: unsigned, low half;
  - op 4: signed, high half (product bits 31:16);
  - op 5: unsigned, high half.
- R3: Op 6 adds the four signed halfword products and returns the sum sign-extended to 64 bits. Op 7 adds the four unsigned products and returns the sum zero-extended.
- R4: Op 8 returns the sum of the unsigned absolute differences of the 8 byte lanes of a and b. Op 9 returns the same sum over the 4 halfword lanes.
- R5: Ops 10, 11 and 12 return the zero-extended sum of all byte lanes, all halfword lanes, or both word lanes of `a`, respectively.
- R6: Ops 13, 14 and 15 gather the top bit of each byte, halfword or word lane of `a`. The bit of lane i goes to result bit i, and all other result bits are zero.
- R7: Op 16 returns `acc` plus the signed 64-bit product of a[31:0] and b[31:0], modulo 2^64.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and the result appears in that same cycle. Operations issued on consecutive cycles each produce their own result. When `in_valid` is low, `result` keeps its previous value.
- R9: Opcodes 17 to 31 produce a zero result and still assert `out_valid`.
- R10: While `rst_n` is low at a clock edge, `result` and `out_valid` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 5 | Operation code |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| acc | input | 64 | Accumulator for op 16 |
| in_valid | input | 1 | Operation issue strobe |
| result | output | 64 | Registered result |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |

## Verification
The assertions check, on every cycle, that `out_valid` tracks `in_valid` with one cycle of delay and that the result holds while idle. They also check that unknown opcodes yield zero, and that the upper bits of byte SAD and sign-gather results stay clear, since these results have a bounded width. The arithmetic content of each opcode can only be shown by the bench's scenarios:

- the signed-versus-unsigned reading of lanes;
- the 32-bit wrap of the pairwise sums;
- the sign extension of the four-product sum;
- the accumulate form.

The bench compares each of these against values it derives from the requirements, including extreme lane values and back-to-back issue.

// File: rtl/pmac_pkg.sv
// Package: shared widths and opcode encoding for the packed multiply-accumulate unit.
// Assumes a 64-bit datapath split into 16-bit multiply lanes.
package pmac_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = 16;
    localparam int OP_W   = 5;
    localparam int N_MUL  = DATA_W / HALF_W;

    typedef enum logic [OP_W-1:0] {
        OP_MADD_S   = 5'd0,
        OP_MADD_U   = 5'd1,
        OP_MULLO_S  = 5'd2,
        OP_MULLO_U  = 5'd3,
        OP_MULHI_S  = 5'd4,
        OP_MULHI_U  = 5'd5,
        OP_MAC_S    = 5'd6,
        OP_MAC_U    = 5'd7,
        OP_SAD_B    = 5'd8,
        OP_SAD_H    = 5'd9,
        OP_SUM_B    = 5'd10,
        OP_SUM_H    = 5'd11,
        OP_SUM_W    = 5'd12,
        OP_MSB_B    = 5'd13,
        OP_MSB_H    = 5'd14,
        OP_MSB_W    = 5'd15,
        OP_ACC_MUL  = 5'd16
    } pmac_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 5'd16;
endpackage

// File: rtl/pmac_lane_mul.sv
// Module: one halfword-lane multiplier.
// Produces a 33-bit two's-complement product: with sgn high both inputs
// are sign-extended, otherwise zero-extended. Bit 32 is the sign of the
// full product, so the value can be extended further by its top bit.
module pmac_lane_mul #(
    parameter int LW = 16
) (
    input  logic [LW-1:0]   x,
    input  logic [LW-1:0]   y,
    input  logic            sgn,
    output logic [2*LW:0]   prod
);
    logic signed [LW:0]     xe;
    logic signed [LW:0]     ye;
    logic signed [2*LW+1:0] full;

    // Extend each lane by one bit according to the signedness request.
    always_comb begin
        xe   = {sgn & x[LW-1], x};
        ye   = {sgn & y[LW-1], y};
        full = xe * ye;
        prod = full[2*LW:0];
    end
endmodule

// File: rtl/pmac_sad.sv
// Module: sum of absolute differences over LW-bit lanes of two operands.
// Lanes are read as unsigned; the scalar sum is zero-extended to DW bits.
module pmac_sad #(
    parameter int DW = 64,
    parameter int LW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sad
);
    localparam int N = DW / LW;

    logic [LW-1:0] diff [N];

    // Per-lane absolute difference.
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [LW-1:0] ai;
        logic [LW-1:0] bi;
        assign ai = a[i*LW +: LW];
        assign bi = b[i*LW +: LW];
        assign diff[i] = (ai >= bi) ? (ai - bi) : (bi - ai);
    end

    // Reduce the lane differences into one scalar.
    always_comb begin
        sad = '0;
        for (int i = 0; i < N; i++) begin
            sad = sad + {{(DW-LW){1'b0}}, diff[i]};
        end
    end
endmodule

// File: rtl/pmac_across.sv
// Module: add-across and sign-bit gather over LW-bit lanes of one operand.
// The sum is zero-extended; msb bit i holds the top bit of lane i.
module pmac_across #(
    parameter int DW = 64,
    parameter int LW = 8
) (
    input  logic [DW-1:0]    a,
    output logic [DW-1:0]    sum,
    output logic [DW/LW-1:0] msb
);
    localparam int N = DW / LW;

    // Gather the top bit of each lane.
    for (genvar i = 0; i < N; i++) begin : g_msb
        assign msb[i] = a[i*LW + LW-1];
    end

    // Unsigned sum of all lanes.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + {{(DW-LW){1'b0}}, a[i*LW +: LW]};
        end
    end
endmodule

// File: rtl/pmac_unit.sv
// Module: packed multiply-accumulate and SAD unit, top level.
// Computes one opcode per cycle and registers the result.
// Latency is one cycle; in_valid may be high on every cycle.
// The result is held while idle. Unknown opcodes yield zero.
// Reset is synchronous and active-low.
module pmac_unit
    import pmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   acc,
    input  logic                in_valid,
    output logic [DATA_W-1:0]   result,
    output logic                out_valid
);
    localparam int PW = 2*HALF_W + 1;

    logic                lane_sgn;
    logic [PW-1:0]       prod [N_MUL];
    logic [DATA_W-1:0]   sad_b, sad_h, sum_b, sum_h, sum_w;
    logic [DATA_W/8-1:0]  msb_b;
    logic [DATA_W/16-1:0] msb_h;
    logic [DATA_W/32-1:0] msb_w;
    logic [DATA_W-1:0]   nxt;
    logic [DATA_W-1:0]   mac_sum;
    logic [2*HALF_W-1:0] pair_lo, pair_hi;
    logic [DATA_W-1:0]   mul_lo, mul_hi;
    logic signed [DATA_W-1:0] wa, wb, wprod;
    logic [DATA_W-1:0]   res_q;
    logic                vld_q;

    // Signed lane reading for the signed multiply opcodes.
    always_comb begin
        lane_sgn = (op == OP_MADD_S) || (op == OP_MULLO_S) ||
                   (op == OP_MULHI_S) || (op == OP_MAC_S);
    end

    for (genvar i = 0; i < N_MUL; i++) begin : g_mul
        pmac_lane_mul #(.LW(HALF_W)) u_mul (
            .x    (a[i*HALF_W +: HALF_W]),
            .y    (b[i*HALF_W +: HALF_W]),
            .sgn  (lane_sgn),
            .prod (prod[i])
        );
    end

    pmac_sad #(.DW(DATA_W), .LW(8))  u_sad_b (.a(a), .b(b), .sad(sad_b));
    pmac_sad #(.DW(DATA_W), .LW(16)) u_sad_h (.a(a), .b(b), .sad(sad_h));
    pmac_across #(.DW(DATA_W), .LW(8))  u_acr_b (.a(a), .sum(sum_b), .msb(msb_b));
    pmac_across #(.DW(DATA_W), .LW(16)) u_acr_h (.a(a), .sum(sum_h), .msb(msb_h));
    pmac_across #(.DW(DATA_W), .LW(32)) u_acr_w (.a(a), .sum(sum_w), .msb(msb_w));

    // Pairwise sums, product-half packing and four-product total.
    always_comb begin
        pair_lo = prod[0][2*HALF_W-1:0] + prod[1][2*HALF_W-1:0];
        pair_hi = prod[2][2*HALF_W-1:0] + prod[3][2*HALF_W-1:0];
        mul_lo  = '0;
        mul_hi  = '0;
        mac_sum = '0;
        for (int i = 0; i < N_MUL; i++) begin
            mul_lo[i*HALF_W +: HALF_W] = prod[i][HALF_W-1:0];
            mul_hi[i*HALF_W +: HALF_W] = prod[i][2*HALF_W-1:HALF_W];
            mac_sum = mac_sum + {{(DATA_W-PW){prod[i][PW-1]}}, prod[i]};
        end
    end

    // Signed 32x32 product for the accumulate form.
    always_comb begin
        wa    = {{(DATA_W/2){a[DATA_W/2-1]}}, a[DATA_W/2-1:0]};
        wb    = {{(DATA_W/2){b[DATA_W/2-1]}}, b[DATA_W/2-1:0]};
        wprod = wa * wb;
    end

    // Opcode result select.
    always_comb begin
        case (op)
            OP_MADD_S, OP_MADD_U:   nxt = {pair_hi, pair_lo};
            OP_MULLO_S, OP_MULLO_U: nxt = mul_lo;
            OP_MULHI_S, OP_MULHI_U: nxt = mul_hi;
            OP_MAC_S, OP_MAC_U:     nxt = mac_sum;
            OP_SAD_B:               nxt = sad_b;
            OP_SAD_H:               nxt = sad_h;
            OP_SUM_B:               nxt = sum_b;
            OP_SUM_H:               nxt = sum_h;
            OP_SUM_W:               nxt = sum_w;
            OP_MSB_B:               nxt = {{(DATA_W-DATA_W/8){1'b0}}, msb_b};
            OP_MSB_H:               nxt = {{(DATA_W-DATA_W/16){1'b0}}, msb_h};
            OP_MSB_W:               nxt = {{(DATA_W-DATA_W/32){1'b0}}, msb_w};
            OP_ACC_MUL:             nxt = acc + wprod;
            default:                nxt = '0;
        endcase
    end

    // Output register: capture on valid issue, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= nxt;
            end
        end
    end

    assign result    = res_q;
    assign out_valid = vld_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R8
    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_LAST) |=> (result == '0)); // R9
    AST_GATHER_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_MSB_B || op == OP_MSB_H || op == OP_MSB_W))
        |=> (result[DATA_W-1:8] == '0)); // R6
    AST_SADB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SAD_B) |=> (result[DATA_W-1:11] == '0)); // R4
endmodule

// File: tb/pmac_unit_test.sv
`timescale 1ns/1ps
module pmac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [63:0] a = '0, b = '0, acc = '0;
    logic        in_valid = 1'b0;
    logic [63:0] result;
    logic        out_valid;
    int          n_chk = 0;
    int          n_bad = 0;

    pmac_unit uut (
        .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .acc(acc),
        .in_valid(in_valid), .result(result), .out_valid(out_valid)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint hw(input logic [63:0] v, input int i, input bit s);
        logic [15:0] f = v[16*i +: 16];
        return s ? longint'($signed(f)) : longint'({48'd0, f});
    endfunction

    // Expected values built from the requirement text.
    function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] x,
                                          input logic [63:0] y, input logic [63:0] c);
        longint p [4];
        longint t;
        logic [63:0] r;
        bit s = (o == 0) || (o == 2) || (o == 4) || (o == 6);
        for (int i = 0; i < 4; i++) p[i] = hw(x, i, s) * hw(y, i, s);
        r = '0;
        case (o)
            0, 1: begin
                r[31:0]  = 32'(p[0] + p[1]);
                r[63:32] = 32'(p[2] + p[3]);
            end
            2, 3: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(p[i]);
            4, 5: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(p[i] >>> 16);
            6, 7: r = 64'(p[0] + p[1] + p[2] + p[3]);
            8: for (int i = 0; i < 8; i++) begin
                t = longint'({56'd0, x[8*i +: 8]}) - longint'({56'd0, y[8*i +: 8]});
                r = r + 64'(t < 0 ? -t : t);
            end
            9: for (int i = 0; i < 4; i++) begin
                t = hw(x, i, 0) - hw(y, i, 0);
                r = r + 64'(t < 0 ? -t : t);
            end
            10: for (int i = 0; i < 8; i++) r = r + {56'd0, x[8*i +: 8]};
            11: for (int i = 0; i < 4; i++) r = r + {48'd0, x[16*i +: 16]};
            12: r = {32'd0, x[31:0]} + {32'd0, x[63:32]};
            13: for (int i = 0; i < 8; i++) r[i] = x[8*i+7];
            14: for (int i = 0; i < 4; i++) r[i] = x[16*i+15];
            15: begin r[0] = x[31]; r[1] = x[63]; end
            16: r = c + 64'(longint'($signed(x[31:0])) * longint'($signed(y[31:0])));
            default: r = '0;
        endcase
        return r;
    endfunction

    // Issue one operation and check its registered result.
    task automatic issue(input string req, input logic [4:0] o, input logic [63:0] x,
                         input logic [63:0] y, input logic [63:0] c);
        @(negedge clk);
        op = o; a = x; b = y; acc = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, result, model(o, x, y, c));
        chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        chk("R10 result", result, 64'd0);
        chk("R10 valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_madd;
        issue("R1 signed", 0, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0003_FFFF, 0);
        issue("R1 unsigned", 1, 64'h1234_FFFF_ABCD_FFFF, 64'h5678_FFFF_0010_FFFF, 0);
        issue("R1 wrap", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk("R1 wrap literal", result, 64'hFFFC0002_FFFC0002);
    endtask

    task automatic t_mul;
        logic [63:0] x = 64'h8000_FFFF_7FFF_1234;
        logic [63:0] y = 64'h8000_0002_7FFF_FEDC;
        for (int o = 2; o <= 5; o++) issue("R2", 5'(o), x, y, 0);
        issue("R2 hi signed neg", 4, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 0);
        chk("R2 hi literal", result, 64'h0000_0000_0000_FFFF);
    endtask

    task automatic t_mac;
        issue("R3 signed", 6, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0);
        chk("R3 signed literal", result, 64'h0000_0001_0000_0000);
        issue("R3 signed neg", 6, 64'h0001_FFFF_7FFF_8000, 64'h0003_0005_8000_7FFF, 0);
        issue("R3 unsigned", 7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk("R3 unsigned literal", result, 64'h0000_0003_FFF8_0004);
    endtask

    task automatic t_sad;
        issue("R4 byte", 8, 64'h00FF_10F0_8001_7F80, 64'hFF00_F010_0180_807F, 0);
        issue("R4 byte max", 8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0);
        chk("R4 byte literal", result, 64'd2040);
        issue("R4 half", 9, 64'h0000_FFFF_1234_8000, 64'hFFFF_0000_4321_7FFF, 0);
    endtask

    task automatic t_across;
        issue("R5 byte", 10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        chk("R5 byte literal", result, 64'd2040);
        issue("R5 half", 11, 64'h8000_FFFF_0001_1234, 0, 0);
        issue("R5 word", 12, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        chk("R5 word literal", result, 64'h1_FFFF_FFFE);
    endtask

    task automatic t_msb;
        issue("R6 byte", 13, 64'h80_00_FF_7F_01_80_00_81, 0, 0);
        chk("R6 byte literal", result, 64'hA5);
        issue("R6 half", 14, 64'h8000_7FFF_FFFF_0001, 0, 0);
        issue("R6 word", 15, 64'h0000_0000_8000_0000, 0, 0);
        chk("R6 word literal", result, 64'h1);
    endtask

    task automatic t_accmul;
        issue("R7 pos", 16, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 64'd5);
        issue("R7 neg", 16, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0003, 64'd1);
        chk("R7 neg literal", result, 64'hFFFF_FFFF_FFFF_FFFE);
        issue("R7 wrap", 16, 64'h8000_0000, 64'h8000_0000, 64'hC000_0000_0000_0000);
    endtask

    task automatic t_unknown;
        issue("R2 prime", 3, 64'h0003_0003_0003_0003, 64'h0002_0002_0002_0002, 0);
        issue("R9 op17", 17, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'h55);
        chk("R9 literal", result, 64'd0);
        issue("R9 op31", 31, 64'h1, 64'h1, 64'h1);
    endtask

    // Back-to-back issue, then idle hold.
    task automatic t_stream;
        logic [63:0] xs [4] = '{64'h0102_0304_0506_0708, 64'hFFFF_0000_8000_7FFF,
                                64'h1111_2222_3333_4444, 64'h8765_4321_0FED_CBA9};
        logic [4:0]  os [4] = '{5'd0, 5'd6, 5'd9, 5'd16};
        logic [63:0] last;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            op = os[i]; a = xs[i]; b = xs[3-i]; acc = 64'd7; in_valid = 1'b1;
            @(negedge clk);
            chk("R8 stream", result, model(os[i], xs[i], xs[3-i], 64'd7));
            chk("R8 stream valid", {63'd0, out_valid}, 64'd1);
        end
        in_valid = 1'b0;
        last = model(os[3], xs[3], xs[0], 64'd7);
        op = 5'd1; a = '1; b = '1;
        @(negedge clk);
        chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R8 idle hold", result, last);
        @(negedge clk);
        chk("R8 idle hold 2", result, last);
    endtask

    task automatic t_reset_mid;
        issue("R5 pre", 10, 64'h0101_0101_0101_0101, 0, 0);
        @(negedge clk);
        op = 5'd10; a = '1; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid result", result, 64'd0);
        chk("R10 mid valid", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_madd;
        t_mul;
        t_mac;
        t_sad;
        t_across;
        t_msb;
        t_accmul;
        t_unknown;
        t_stream;
        t_reset_mid;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule